// File: doc/BRIEF.md
# Predicated Execution and Condition Flag Unit

This unit decides, for every instruction, whether its effects are allowed to happen. Each instruction carries a 4-bit condition code. The unit tests that code against a stored set of four condition flags: negative, zero, carry and overflow. The resulting enable gates the register-file write and the memory write of the instruction. An instruction that fails its test still takes its normal cycles, but it changes nothing, so fetch and decode carry on as usual.

The flags change only at the step strobe. They take the ALU's flag outputs in two cases: when the instruction asks for it through its set-flags bit, or when the instruction belongs to the compare class (subtract, add, AND or XOR with no result written back). An instruction that fails its condition never writes the flags. Because of this, a chain of flag-setting instructions sees, at each step, the flags left by the one before it.

Top module: `cond_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags; `flags_o` presents them as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R2: Condition code 1110 (always) gives `exec_en_o` = 1 for any flag values; code 1111 (never) gives `exec_en_o` = 0.
- R3: The single-flag codes behave as follows: 0000 needs Z=1, 0001 needs Z=0, 0010 needs C=1, 0011 needs C=0, 0100 needs N=1, 0101 needs N=0, 0110 needs V=1, 0111 needs V=0.
- R4: The compound codes behave as follows: 1000 needs C=1 and Z=0, 1001 needs C=0 or Z=1, 1010 needs N=V, 1011 needs N≠V, 1100 needs Z=0 and N=V, 1101 needs Z=1 or N≠V.
- R5: `exec_en_o` is combinational from `cond_i` and the stored flags, and is valid in the same cycle as the condition.
- R6: When `set_flags_i`=0 and `is_compare_i`=0, a step leaves the flags unchanged whatever the ALU flags are.
- R7: When `set_flags_i`=1 and the condition passes, the flags take the ALU flags at the clock edge where `step_i`=1.
- R8: A compare-class instruction whose condition passes updates the flags even with `set_flags_i`=0.
- R9: An instruction whose condition fails leaves the flags unchanged even with `set_flags_i`=1 or `is_compare_i`=1.
- R10: With `step_i`=0 the flags hold, whatever the other inputs are.
- R11: `reg_wr_en_o` equals `exec_en_o` with compare-class instructions masked, so a compare never writes a destination register.
- R12: In back-to-back flag-setting steps, each condition is tested against the flags written by the step before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Condition code of the current instruction |
| set_flags_i | input | 1 | Instruction requests a flag update |
| is_compare_i | input | 1 | Instruction is compare-class (no writeback, always sets flags) |
| alu_n_i | input | 1 | ALU negative result flag |
| alu_z_i | input | 1 | ALU zero result flag |
| alu_c_i | input | 1 | ALU carry flag |
| alu_v_i | input | 1 | ALU overflow flag |
| step_i | input | 1 | Strobe marking the cycle in which flags may be written |
| exec_en_o | output | 1 | Condition passed; gates memory and register writes |
| reg_wr_en_o | output | 1 | Destination register write permitted |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench first loads known flag patterns. It then walks every condition code, including both sides of each compound test, so a swapped pair such as HI/LS or a GE that compares the wrong flags shows up as a wrong enable. It looks for the ways flags could be written when they should not be: a plain instruction that still copies the ALU flags, a write with no strobe, and a failed instruction with its set-flags bit set. A design that makes any of these mistakes would corrupt the flags seen by the next instruction. The bench also checks that compares update the flags without the set-flags bit while suppressing the register write, and it runs a three-instruction chain in which a stale or early flag write would turn the last step's pass or fail the wrong way.

// File: rtl/cond_exec_pkg.sv
package cond_exec_pkg;

    localparam int COND_W = 4;
    localparam int FLAG_W = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [COND_W-1:0] {
        CC_ZSET  = 4'b0000,
        CC_ZCLR  = 4'b0001,
        CC_CSET  = 4'b0010,
        CC_CCLR  = 4'b0011,
        CC_NSET  = 4'b0100,
        CC_NCLR  = 4'b0101,
        CC_VSET  = 4'b0110,
        CC_VCLR  = 4'b0111,
        CC_UGT   = 4'b1000,
        CC_ULE   = 4'b1001,
        CC_SGE   = 4'b1010,
        CC_SLT   = 4'b1011,
        CC_SGT   = 4'b1100,
        CC_SLE   = 4'b1101,
        CC_ALL   = 4'b1110,
        CC_NONE  = 4'b1111
    } cond_e;

    function automatic logic cond_holds(cond_e c, flags_t f);
        logic sign_ok;
        sign_ok = (f.n == f.v);
        case (c)
            CC_ZSET: return f.z;
            CC_ZCLR: return !f.z;
            CC_CSET: return f.c;
            CC_CCLR: return !f.c;
            CC_NSET: return f.n;
            CC_NCLR: return !f.n;
            CC_VSET: return f.v;
            CC_VCLR: return !f.v;
            CC_UGT:  return f.c && !f.z;
            CC_ULE:  return !f.c || f.z;
            CC_SGE:  return sign_ok;
            CC_SLT:  return !sign_ok;
            CC_SGT:  return !f.z && sign_ok;
            CC_SLE:  return f.z || !sign_ok;
            CC_ALL:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_exec_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  flags_t            flags_i,
    output logic              pass_o
);
    always_comb begin
        pass_o = cond_holds(cond_e'(cond_i), flags_i);
    end

    always_comb begin
        if (cond_i == CC_ALL)  assert_always_runs_R2: assert (pass_o === 1'b1);
        if (cond_i == CC_NONE) assert_never_runs_R2:  assert (pass_o === 1'b0);
    end
endmodule

// File: rtl/flag_store.sv
module flag_store
    import cond_exec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_i,
    input  flags_t next_i,
    output flags_t flags_o
);
    flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst)       flags_q <= '0;
        else if (wr_i) flags_q <= next_i;
    end

    assign flags_o = flags_q;

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(flags_q));
    assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> flags_q == $past(next_i));
endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
    import cond_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_W-1:0] cond_i,
    input  logic              set_flags_i,
    input  logic              is_compare_i,
    input  logic              alu_n_i,
    input  logic              alu_z_i,
    input  logic              alu_c_i,
    input  logic              alu_v_i,
    input  logic              step_i,
    output logic              exec_en_o,
    output logic              reg_wr_en_o,
    output logic [FLAG_W-1:0] flags_o
);
    flags_t cur_flags;
    flags_t alu_flags;
    logic   pass;
    logic   upd_req;
    logic   flag_wr;

    assign alu_flags = '{n: alu_n_i, z: alu_z_i, c: alu_c_i, v: alu_v_i};

    cond_eval u_eval (
        .cond_i  (cond_i),
        .flags_i (cur_flags),
        .pass_o  (pass)
    );

    always_comb begin
        upd_req = set_flags_i || is_compare_i;
        flag_wr = step_i && pass && upd_req;
    end

    flag_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (flag_wr),
        .next_i  (alu_flags),
        .flags_o (cur_flags)
    );

    assign exec_en_o   = pass;
    assign reg_wr_en_o = pass && !is_compare_i;
    assign flags_o     = cur_flags;

    assert_failed_keeps_flags_R9: assert property (@(posedge clk) disable iff (rst)
        !exec_en_o |=> $stable(flags_o));
    assert_no_strobe_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(flags_o));
    assert_compare_updates_R8: assert property (@(posedge clk) disable iff (rst)
        (step_i && exec_en_o && is_compare_i) |=>
        flags_o == $past({alu_n_i, alu_z_i, alu_c_i, alu_v_i}));
    assert_compare_no_write_R11: assert property (@(posedge clk) disable iff (rst)
        is_compare_i |-> !reg_wr_en_o);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> flags_o == '0);
endmodule

// File: tb/cond_exec_unit_tb.sv
module cond_exec_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cond_i = 4'b1110;
    logic       set_flags_i = 1'b0;
    logic       is_compare_i = 1'b0;
    logic [3:0] alu = 4'b0000;
    logic       step_i = 1'b0;
    logic       exec_en_o;
    logic       reg_wr_en_o;
    logic [3:0] flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cond_exec_unit u_dut (
        .clk          (clk),
        .rst          (rst),
        .cond_i       (cond_i),
        .set_flags_i  (set_flags_i),
        .is_compare_i (is_compare_i),
        .alu_n_i      (alu[3]),
        .alu_z_i      (alu[2]),
        .alu_c_i      (alu[1]),
        .alu_v_i      (alu[0]),
        .step_i       (step_i),
        .exec_en_o    (exec_en_o),
        .reg_wr_en_o  (reg_wr_en_o),
        .flags_o      (flags_o)
    );

    // entry = {flags NZCV, condition code, expected enable}
    localparam logic [8:0] VEC [24] = '{
        9'b0100_0000_1, 9'b0000_0000_0, 9'b0000_0001_1, 9'b0100_0001_0,
        9'b0010_0010_1, 9'b0010_0011_0, 9'b0000_0011_1, 9'b1000_0100_1,
        9'b1000_0101_0, 9'b0001_0110_1, 9'b0001_0111_0, 9'b0010_1000_1,
        9'b0110_1000_0, 9'b0110_1001_1, 9'b0000_1001_1, 9'b1001_1010_1,
        9'b1000_1011_1, 9'b0000_1010_1, 9'b0000_1100_1, 9'b0100_1100_0,
        9'b1000_1101_1, 9'b0000_1101_0, 9'b1111_1110_1, 9'b0000_1111_0
    };

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    // one instruction step: drive at negedge, let it take the edge, return to idle
    task automatic step(logic [3:0] c, logic sf, logic cmp, logic [3:0] a, logic strobe);
        @(negedge clk);
        cond_i = c; set_flags_i = sf; is_compare_i = cmp; alu = a; step_i = strobe;
        @(posedge clk);
        #1;
        step_i = 1'b0; set_flags_i = 1'b0; is_compare_i = 1'b0;
    endtask

    task automatic load_flags(logic [3:0] f);
        step(4'b1110, 1'b1, 1'b0, f, 1'b1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 reset flags", flags_o, 4'b0000);
        cond_i = 4'b0000; #1;
        check("R5 EQ after reset", {3'b0, exec_en_o}, 4'b0000);

        foreach (VEC[i]) begin
            load_flags(VEC[i][8:5]);
            @(negedge clk);
            cond_i = VEC[i][4:1];
            #1;
            if (VEC[i][4:1] >= 4'b1110)
                check("R2 always/never", {3'b0, exec_en_o}, {3'b0, VEC[i][0]});
            else if (VEC[i][4])
                check("R4 compound code", {3'b0, exec_en_o}, {3'b0, VEC[i][0]});
            else
                check("R3 single code", {3'b0, exec_en_o}, {3'b0, VEC[i][0]});
        end

        // R7 capture on strobe with set-flags
        load_flags(4'b1010);
        check("R7 flags captured", flags_o, 4'b1010);

        // R6 plain instruction leaves flags
        step(4'b1110, 1'b0, 1'b0, 4'b0101, 1'b1);
        check("R6 no set-flags keeps flags", flags_o, 4'b1010);
        cond_i = 4'b1110; #1;
        check("R11 plain write enable", {2'b0, exec_en_o, reg_wr_en_o}, 4'b0011);

        // R10 no strobe
        step(4'b1110, 1'b1, 1'b1, 4'b0101, 1'b0);
        check("R10 no strobe keeps flags", flags_o, 4'b1010);

        // R9 failed condition with set-flags: Z=0 so EQ fails
        @(negedge clk);
        cond_i = 4'b0000; set_flags_i = 1'b1; alu = 4'b1111; #1;
        check("R9 failed enables", {2'b0, exec_en_o, reg_wr_en_o}, 4'b0000);
        step(4'b0000, 1'b1, 1'b0, 4'b1111, 1'b1);
        check("R9 failed keeps flags", flags_o, 4'b1010);
        step(4'b0000, 1'b0, 1'b1, 4'b1111, 1'b1);
        check("R9 failed compare keeps flags", flags_o, 4'b1010);

        // R8 compare updates without set-flags, no register write
        @(negedge clk);
        cond_i = 4'b1110; is_compare_i = 1'b1; #1;
        check("R11 compare masks reg write", {2'b0, exec_en_o, reg_wr_en_o}, 4'b0010);
        step(4'b1110, 1'b0, 1'b1, 4'b0010, 1'b1);
        check("R8 compare updates flags", flags_o, 4'b0010);

        // R12 chain: set Z, EQ passes and clears Z, EQ then fails
        load_flags(4'b0000);
        @(negedge clk); cond_i = 4'b1110; #1;
        step(4'b1110, 1'b1, 1'b0, 4'b0100, 1'b1);
        @(negedge clk); cond_i = 4'b0000; #1;
        check("R12 second step passes", {3'b0, exec_en_o}, 4'b0001);
        step(4'b0000, 1'b1, 1'b0, 4'b0000, 1'b1);
        check("R12 second step wrote", flags_o, 4'b0000);
        @(negedge clk); cond_i = 4'b0000; #1;
        check("R12 third step fails", {3'b0, exec_en_o}, 4'b0000);
        step(4'b0000, 1'b1, 1'b0, 4'b0100, 1'b1);
        check("R12 third step kept flags", flags_o, 4'b0000);

        // R1 reset mid-run
        load_flags(4'b1111);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check("R1 reset clears flags", flags_o, 4'b0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule